// File: doc/BRIEF.md
# Four-Channel DMA Transfer Controller

This block moves bytes between memory and peripherals without processor involvement. A host programs each of four channels through a small byte-wide register port. Each channel has a 16-bit start address, a 14-bit byte count, a cycle type and a mask bit. A peripheral asks for service by raising its request line. The controller then asks the processor for the bus with a hold request. Once hold acknowledge arrives, the controller runs one byte transfer at a time: an address cycle, then a strobe cycle, with the acknowledge line low for the chosen channel. After every byte it picks again among the pending channels. When none is left, it gives the bus back.

The DMA side uses plain strobes and levels rather than a valid/ready stream. The `ready` input is the only back-pressure. While `ready` is low, the strobe cycle is stretched and the address, acknowledge and strobes all hold. The host port is also plain: select, a read or write strobe, a 4-bit register index and a data byte, with read data returned combinationally in the same cycle.

Top module: `dma4_ctrl`

## Requirements
- R1: Reset leaves the controller in the following state:
  - `hold_req`, `bus_own`, `tc` and `mark` are low.
  - `dack_n` and all four strobes are high.
  - All channels are masked.
  - The status register reads 0.
- R2: The host register map is as follows:
  - Index 2n holds channel n's address and index 2n+1 holds its count.
  - Both are accessed low byte first, then high byte, through one shared byte pointer. The pointer toggles on every access to indices 0–7 and is cleared by reset or by a write to index 11.
  - Index 9 sets a channel's cycle type: data bits [1:0] give the channel and bits [3:2] the type (00 verify, 01 write, 10 read).
  - Index 10 sets or clears a channel's mask: data bits [1:0] give the channel and bit 2 is 1 to mask.
  - Index 8 written sets rotating priority from bit 0. Index 8 read returns the status register.
- R3: A channel is eligible when its request is high, it is unmasked and its count is non-zero. Any eligible channel raises `hold_req`. `bus_own`, `dack_n` and the strobes stay inactive until `hold_ack` is high.
- R4: Each byte takes one address cycle followed by one or more strobe cycles. In both, `mem_addr` carries the serviced channel's current address and only that channel's `dack_n` bit is low.
- R5: The strobes depend on the cycle type:
  - Read asserts `memr_n` and `iow_n`.
  - Write asserts `ior_n` and `memw_n`.
  - Verify asserts no strobe.
- R6: Each completed byte increments the channel's address and decrements its count. The address carries across the byte boundary, and verify cycles update both registers too.
- R7: While `ready` is low in a strobe cycle, the strobes, `mem_addr` and `dack_n` hold and no byte completes.
- R8: `tc` pulses in the strobe cycle that moves a channel's last byte. It also sets that channel's bit in status bits [3:0]. A host read of status clears those bits. Status bits [7:4] show the raw request lines.
- R9: `mark` pulses on the strobe cycle of every 128th byte moved on a channel since its count was last written.
- R10: With fixed priority, channel 0 is highest and channel 3 is lowest, and the choice is made again before every byte.
- R11: With rotating priority, the channel serviced last becomes the lowest priority for the next choice.
- R12: When no channel is eligible at a choice point, `bus_own` drops first. `hold_req` drops one cycle later. No new hold request is raised while `hold_ack` is still high.
- R13: A request from a masked channel or a channel with a zero count is ignored: `hold_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_sel | input | 1 | Host register port select |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 4 | Register index |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid while selected and reading |
| drq | input | 4 | Per-channel service request |
| dack_n | output | 4 | Per-channel acknowledge, active low |
| hold_req | output | 1 | Bus hold request to the processor |
| hold_ack | input | 1 | Hold acknowledge from the processor |
| ready | input | 1 | Low inserts wait states in the strobe cycle |
| bus_own | output | 1 | High while the controller drives the bus |
| mem_addr | output | 16 | Transfer address |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| ior_n | output | 1 | Peripheral read strobe, active low |
| iow_n | output | 1 | Peripheral write strobe, active low |
| tc | output | 1 | Terminal count pulse |
| mark | output | 1 | Every-128-bytes pulse |

## Verification
The bench builds the controller with its default parameters: four channels, a 16-bit address, a 14-bit count and a marker modulus of 128. With the modulus left at 128, a 130-byte verify run reaches the marker on byte 128 and the terminal count two bytes later inside one bus tenure. The 16-bit address lets a short run starting at 0x00FE show the carry into the high byte. The four channels are enough to show fixed order and rotating order side by side on the same pair of channels.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  typedef enum logic [1:0] {
    XK_VERIFY = 2'b00,
    XK_WRITE  = 2'b01,
    XK_READ   = 2'b10,
    XK_SPARE  = 2'b11
  } xfer_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_SEL,
    ST_ADDR,
    ST_XFER,
    ST_REL
  } eng_state_e;

  localparam logic [3:0] IDX_CMD   = 4'd8;
  localparam logic [3:0] IDX_MODE  = 4'd9;
  localparam logic [3:0] IDX_MASK  = 4'd10;
  localparam logic [3:0] IDX_CLRBP = 4'd11;
endpackage

// File: rtl/dma4_chan.sv
module dma4_chan #(
  parameter int AW = 16,
  parameter int CW = 14,
  parameter int MB = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_addr_lo,
  input  logic          ld_addr_hi,
  input  logic          ld_cnt_lo,
  input  logic          ld_cnt_hi,
  input  logic          step,
  input  logic [7:0]    wdata,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] cnt_q,
  output logic          mark_hit
);
  logic [MB-1:0] mk_q;
  logic          any_ld;

  assign any_ld   = ld_addr_lo | ld_addr_hi | ld_cnt_lo | ld_cnt_hi;
  assign mark_hit = step && (&mk_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cnt_q  <= '0;
      mk_q   <= '0;
    end else begin
      if (ld_addr_lo)      addr_q <= {addr_q[AW-1:8], wdata};
      else if (ld_addr_hi) addr_q <= AW'({wdata, addr_q[7:0]});
      else if (step)       addr_q <= addr_q + 1'b1;

      if (ld_cnt_lo)       cnt_q <= {cnt_q[CW-1:8], wdata};
      else if (ld_cnt_hi)  cnt_q <= CW'({wdata, cnt_q[7:0]});
      else if (step)       cnt_q <= cnt_q - 1'b1;

      if (ld_cnt_lo || ld_cnt_hi) mk_q <= '0;
      else if (step)              mk_q <= mk_q + 1'b1;
    end
  end

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !any_ld) |=> (addr_q == $past(addr_q) + 1'b1));
  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !any_ld) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/dma4_arbiter.sv
module dma4_arbiter #(
  parameter int NCH = 4,
  parameter int IW  = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] req,
  input  logic           rotate,
  input  logic           take,
  output logic           any,
  output logic [IW-1:0]  win
);
  logic [IW-1:0] last_q;
  logic [IW-1:0] base;

  always_comb begin
    if (!rotate)                     base = '0;
    else if (last_q == IW'(NCH - 1)) base = '0;
    else                             base = last_q + 1'b1;
  end

  always_comb begin
    any = 1'b0;
    win = '0;
    for (int k = 0; k < NCH; k++) begin
      if (!any && req[(int'(base) + k) % NCH]) begin
        any = 1'b1;
        win = IW'((int'(base) + k) % NCH);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       last_q <= IW'(NCH - 1);
    else if (take) last_q <= win;
  end

  // R10
  gnt_valid_chk: assert property (@(posedge clk) disable iff (rst)
    any |-> req[win]);
  // R10
  fixed_top_chk: assert property (@(posedge clk) disable iff (rst)
    (!rotate && req[0]) |-> (win == '0));
endmodule

// File: rtl/dma4_host.sv
module dma4_host #(
  parameter int NCH = 4,
  parameter int IW  = 2,
  parameter int AW  = 16,
  parameter int CW  = 14
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sel,
  input  logic                    wr,
  input  logic                    rd,
  input  logic [3:0]              addr,
  input  logic [7:0]              wdata,
  output logic [7:0]              rdata,
  input  logic [NCH-1:0][AW-1:0]  ch_addr,
  input  logic [NCH-1:0][CW-1:0]  ch_cnt,
  input  logic [NCH-1:0]          tc_hit,
  input  logic [NCH-1:0]          drq,
  output logic [NCH-1:0]          ld_al,
  output logic [NCH-1:0]          ld_ah,
  output logic [NCH-1:0]          ld_cl,
  output logic [NCH-1:0]          ld_ch,
  output logic [NCH-1:0]          mask,
  output logic [NCH-1:0][1:0]     kind,
  output logic                    rotate
);
  import dma4_pkg::*;

  logic           ptr_q;
  logic [NCH-1:0] tc_q;
  logic           chan_acc, chan_wr, stat_rd;
  logic [IW-1:0]  ci;
  logic [IW-1:0]  wch;

  assign ci       = addr[IW:1];
  assign wch      = wdata[IW-1:0];
  assign chan_acc = sel && (wr || rd) && !addr[3];
  assign chan_wr  = sel && wr && !addr[3];
  assign stat_rd  = sel && rd && (addr == IDX_CMD);

  for (genvar i = 0; i < NCH; i++) begin : g_ld
    assign ld_al[i] = chan_wr && (ci == IW'(i)) && !addr[0] && !ptr_q;
    assign ld_ah[i] = chan_wr && (ci == IW'(i)) && !addr[0] &&  ptr_q;
    assign ld_cl[i] = chan_wr && (ci == IW'(i)) &&  addr[0] && !ptr_q;
    assign ld_ch[i] = chan_wr && (ci == IW'(i)) &&  addr[0] &&  ptr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= 1'b0;
      tc_q   <= '0;
      mask   <= '1;
      kind   <= '0;
      rotate <= 1'b0;
    end else begin
      if (chan_acc)                                 ptr_q <= !ptr_q;
      else if (sel && wr && addr == IDX_CLRBP)      ptr_q <= 1'b0;
      if (sel && wr && addr == IDX_CMD)             rotate <= wdata[0];
      if (sel && wr && addr == IDX_MODE)            kind[wch] <= wdata[3:2];
      if (sel && wr && addr == IDX_MASK)            mask[wch] <= wdata[2];
      tc_q <= (tc_q & ~{NCH{stat_rd}}) | tc_hit;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel && rd) begin
      if (!addr[3]) begin
        if (!addr[0]) rdata = ptr_q ? 8'(ch_addr[ci] >> 8) : ch_addr[ci][7:0];
        else          rdata = ptr_q ? 8'(ch_cnt[ci] >> 8)  : ch_cnt[ci][7:0];
      end else if (addr == IDX_CMD) begin
        rdata = {4'(drq), 4'(tc_q)};
      end
    end
  end

  // R8
  stat_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !(|tc_hit)) |=> (tc_q == '0));
  // R2
  ptr_flip_chk: assert property (@(posedge clk) disable iff (rst)
    chan_acc |=> (ptr_q != $past(ptr_q)));
endmodule

// File: rtl/dma4_engine.sv
module dma4_engine #(
  parameter int NCH = 4,
  parameter int IW  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          any_pend,
  input  logic          hold_ack,
  input  logic          ready,
  input  logic          arb_any,
  input  logic [IW-1:0] arb_win,
  output logic          hold_req,
  output logic          bus_own,
  output logic          addr_phase,
  output logic          xfer_phase,
  output logic          step_go,
  output logic          take,
  output logic [IW-1:0] act_ch
);
  import dma4_pkg::*;

  eng_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (any_pend && !hold_ack) st_d = ST_REQ;
      ST_REQ:  if (hold_ack)              st_d = ST_SEL;
      ST_SEL:  st_d = arb_any ? ST_ADDR : ST_REL;
      ST_ADDR: st_d = ST_XFER;
      ST_XFER: if (ready)                 st_d = ST_SEL;
      ST_REL:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      act_ch <= '0;
    end else begin
      st_q <= st_d;
      if (take) act_ch <= arb_win;
    end
  end

  assign hold_req   = (st_q != ST_IDLE);
  assign bus_own    = (st_q == ST_SEL) || (st_q == ST_ADDR) || (st_q == ST_XFER);
  assign addr_phase = (st_q == ST_ADDR) || (st_q == ST_XFER);
  assign xfer_phase = (st_q == ST_XFER);
  assign step_go    = xfer_phase && ready;
  assign take       = (st_q == ST_SEL) && arb_any;

  // R3
  own_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_own) |-> hold_ack);
  // R12
  own_in_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bus_own |-> hold_req);
  // R12
  release_order_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_req) |-> !$past(bus_own));
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl #(
  parameter int NCH      = 4,
  parameter int AW       = 16,
  parameter int CW       = 14,
  parameter int MARK_MOD = 128
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           host_sel,
  input  logic           host_wr,
  input  logic           host_rd,
  input  logic [3:0]     host_addr,
  input  logic [7:0]     host_wdata,
  output logic [7:0]     host_rdata,
  input  logic [NCH-1:0] drq,
  output logic [NCH-1:0] dack_n,
  output logic           hold_req,
  input  logic           hold_ack,
  input  logic           ready,
  output logic           bus_own,
  output logic [AW-1:0]  mem_addr,
  output logic           memr_n,
  output logic           memw_n,
  output logic           ior_n,
  output logic           iow_n,
  output logic           tc,
  output logic           mark
);
  import dma4_pkg::*;

  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int MB = $clog2(MARK_MOD);

  logic [NCH-1:0][AW-1:0] ch_addr;
  logic [NCH-1:0][CW-1:0] ch_cnt;
  logic [NCH-1:0][1:0]    kind;
  logic [NCH-1:0]         ld_al, ld_ah, ld_cl, ld_ch, mask, step, pend, mk_hit, tc_hit;
  logic                   rotate, arb_any, take, addr_phase, xfer_phase, step_go;
  logic [IW-1:0]          arb_win, act_ch;
  xfer_kind_e             act_kind;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma4_chan #(.AW(AW), .CW(CW), .MB(MB)) u_chan (
      .clk(clk), .rst(rst),
      .ld_addr_lo(ld_al[i]), .ld_addr_hi(ld_ah[i]),
      .ld_cnt_lo(ld_cl[i]), .ld_cnt_hi(ld_ch[i]),
      .step(step[i]), .wdata(host_wdata),
      .addr_q(ch_addr[i]), .cnt_q(ch_cnt[i]), .mark_hit(mk_hit[i])
    );
    assign pend[i]   = drq[i] && !mask[i] && (ch_cnt[i] != '0);
    assign step[i]   = step_go && (act_ch == IW'(i));
    assign tc_hit[i] = step[i] && (ch_cnt[i] == CW'(1));
    assign dack_n[i] = !(addr_phase && (act_ch == IW'(i)));
  end

  dma4_host #(.NCH(NCH), .IW(IW), .AW(AW), .CW(CW)) u_host (
    .clk(clk), .rst(rst), .sel(host_sel), .wr(host_wr), .rd(host_rd),
    .addr(host_addr), .wdata(host_wdata), .rdata(host_rdata),
    .ch_addr(ch_addr), .ch_cnt(ch_cnt), .tc_hit(tc_hit), .drq(drq),
    .ld_al(ld_al), .ld_ah(ld_ah), .ld_cl(ld_cl), .ld_ch(ld_ch),
    .mask(mask), .kind(kind), .rotate(rotate)
  );

  dma4_arbiter #(.NCH(NCH), .IW(IW)) u_arb (
    .clk(clk), .rst(rst), .req(pend), .rotate(rotate), .take(take),
    .any(arb_any), .win(arb_win)
  );

  dma4_engine #(.NCH(NCH), .IW(IW)) u_eng (
    .clk(clk), .rst(rst), .any_pend(|pend), .hold_ack(hold_ack), .ready(ready),
    .arb_any(arb_any), .arb_win(arb_win), .hold_req(hold_req), .bus_own(bus_own),
    .addr_phase(addr_phase), .xfer_phase(xfer_phase), .step_go(step_go),
    .take(take), .act_ch(act_ch)
  );

  assign act_kind = xfer_kind_e'(kind[act_ch]);
  assign mem_addr = addr_phase ? ch_addr[act_ch] : '0;
  assign memr_n   = !(xfer_phase && act_kind == XK_READ);
  assign iow_n    = !(xfer_phase && act_kind == XK_READ);
  assign ior_n    = !(xfer_phase && act_kind == XK_WRITE);
  assign memw_n   = !(xfer_phase && act_kind == XK_WRITE);
  assign tc       = |tc_hit;
  assign mark     = |(mk_hit & step);

  // R4
  dack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~dack_n));
  // R5
  rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!memr_n && !memw_n) && !(!ior_n && !iow_n));
  // R5
  strobe_owned_chk: assert property (@(posedge clk) disable iff (rst)
    (!memr_n || !memw_n || !ior_n || !iow_n) |-> (bus_own && !(&dack_n)));
  // R7
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_phase && !ready) |=> (xfer_phase && $stable(mem_addr) && $stable(dack_n)));
  // R8
  tc_in_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    (tc || mark) |-> (xfer_phase && ready));
endmodule

// File: tb/sim_dma4_ctrl.sv
module sim_dma4_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_sel = 0, host_wr = 0, host_rd = 0;
  logic [3:0]  host_addr = 0;
  logic [7:0]  host_wdata = 0;
  logic [7:0]  host_rdata;
  logic [3:0]  drq = 0;
  logic [3:0]  dack_n;
  logic        hold_req, hold_ack = 0, ready = 1;
  logic        bus_own;
  logic [15:0] mem_addr;
  logic        memr_n, memw_n, ior_n, iow_n, tc, mark;

  typedef struct {
    int          ch;
    logic [15:0] a;
    logic [3:0]  strb;
    logic        tc;
    logic        mk;
  } exp_t;

  exp_t q[$];
  int   compared = 0;
  int   mismatched = 0;
  logic ack_en = 1'b1;
  logic [1:0] ack_pipe = 2'b00;

  localparam logic [1:0] K_VER = 2'b00, K_WR = 2'b01, K_RD = 2'b10;

  dma4_ctrl u0 (
    .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .drq(drq), .dack_n(dack_n), .hold_req(hold_req), .hold_ack(hold_ack),
    .ready(ready), .bus_own(bus_own), .mem_addr(mem_addr), .memr_n(memr_n),
    .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n), .tc(tc), .mark(mark)
  );

  initial forever #4 clk = ~clk;

  task automatic chk_eq(input string tag, input int act, input int expv);
    compared++;
    if (act != expv) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // processor model: acknowledge follows hold request two cycles later
  initial begin
    forever begin
      @(posedge clk); #1;
      hold_ack = ack_pipe[1];
      ack_pipe = {ack_pipe[0], hold_req & ack_en};
    end
  end

  // monitor: pops one expected item per completed byte
  initial begin
    logic prev_low, prev_own, prev_hold;
    prev_low = 0; prev_own = 0; prev_hold = 0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        logic done;
        int   ch;
        done = (dack_n != 4'hf) && prev_low && ready;
        ch = -1;
        for (int i = 0; i < 4; i++) if (!dack_n[i]) ch = i;
        if (bus_own && !hold_ack) begin
          mismatched++; $display("FAIL R3: bus owned without acknowledge, actual 1 expected 0");
        end
        if (prev_hold && !hold_req && prev_own) begin
          mismatched++; $display("FAIL R12: hold dropped with bus still owned, actual 1 expected 0");
        end
        if (!done && (tc || mark)) begin
          mismatched++; $display("FAIL R8: tc/mark outside a completing byte, actual %0b%0b expected 00", tc, mark);
        end
        if (done) begin
          if (q.size() == 0) begin
            mismatched++; $display("FAIL R4: unexpected byte on channel %0d, actual 1 expected 0", ch);
          end else begin
            exp_t e;
            e = q.pop_front();
            chk_eq("R4 channel", ch, e.ch);
            chk_eq("R4 address", int'(mem_addr), int'(e.a));
            chk_eq("R5 strobes", int'({memr_n, memw_n, ior_n, iow_n}), int'(e.strb));
            chk_eq("R8 tc", int'(tc), int'(e.tc));
            chk_eq("R9 mark", int'(mark), int'(e.mk));
          end
        end
        prev_low  = (dack_n != 4'hf);
        prev_own  = bus_own;
        prev_hold = hold_req;
      end
    end
  end

  // watchdog
  initial begin
    #(8 * 150000);
    mismatched++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    summary_and_end();
  end

  task automatic host_write(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_sel = 0; host_wr = 0;
  endtask

  task automatic host_read(input logic [3:0] a, output logic [7:0] d);
    @(posedge clk); #1;
    host_sel = 1; host_rd = 1; host_addr = a;
    @(negedge clk);
    d = host_rdata;
    @(posedge clk); #1;
    host_sel = 0; host_rd = 0;
  endtask

  task automatic program_ch(input int ch, input logic [15:0] a, input logic [13:0] n,
                            input logic [1:0] k);
    host_write(4'd11, 8'h00);
    host_write(4'(2 * ch), a[7:0]);
    host_write(4'(2 * ch), a[15:8]);
    host_write(4'(2 * ch + 1), n[7:0]);
    host_write(4'(2 * ch + 1), 8'({2'b00, n[13:8]}));
    host_write(4'd9, 8'({k, 2'(ch)}));
    host_write(4'd10, 8'(ch));
  endtask

  function automatic logic [3:0] strb_of(input logic [1:0] k);
    case (k)
      K_RD:    return 4'b0110;
      K_WR:    return 4'b1001;
      default: return 4'b1111;
    endcase
  endfunction

  task automatic push_item(input int ch, input logic [15:0] a, input logic [1:0] k,
                           input logic t, input logic m);
    exp_t e;
    e.ch = ch; e.a = a; e.strb = strb_of(k); e.tc = t; e.mk = m;
    q.push_back(e);
  endtask

  task automatic push_run(input int ch, input logic [15:0] a, input int n, input logic [1:0] k);
    for (int i = 1; i <= n; i++)
      push_item(ch, a + 16'(i - 1), k, (i == n), (i % 128 == 0));
  endtask

  task automatic drain(input string tag);
    int n;
    n = 0;
    while ((q.size() != 0 || hold_req) && n < 3000) begin
      @(negedge clk); n++;
    end
    chk_eq({tag, " queue drained and bus released"}, int'(q.size() == 0 && !hold_req), 1);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1 reset state
    chk_eq("R1 hold_req", int'(hold_req), 0);
    chk_eq("R1 bus_own", int'(bus_own), 0);
    chk_eq("R1 dack_n", int'(dack_n), 4'hf);
    chk_eq("R1 strobes", int'({memr_n, memw_n, ior_n, iow_n}), 4'hf);
    chk_eq("R1 tc/mark", int'({tc, mark}), 0);
    host_read(4'd8, d);
    chk_eq("R1 status", int'(d), 0);
    // R1 channels start masked: load a count without unmasking
    host_write(4'd11, 8'h00);
    host_write(4'd1, 8'h02);
    host_write(4'd1, 8'h00);
    @(posedge clk); #1 drq = 4'b0001;
    repeat (8) @(negedge clk);
    chk_eq("R1 masked after reset keeps hold_req low", int'(hold_req), 0);
    @(posedge clk); #1 drq = 4'b0000;

    // R2 register access and byte pointer
    program_ch(0, 16'h1234, 14'd3, K_RD);
    host_write(4'd11, 8'h00);
    host_read(4'd0, d); chk_eq("R2 address low byte", int'(d), 8'h34);
    host_read(4'd0, d); chk_eq("R2 address high byte", int'(d), 8'h12);
    host_read(4'd1, d); chk_eq("R2 count low byte", int'(d), 8'h03);
    host_read(4'd1, d); chk_eq("R2 count high byte", int'(d), 8'h00);
    host_read(4'd0, d); host_write(4'd11, 8'h00);
    host_read(4'd0, d); chk_eq("R2 pointer cleared by index 11", int'(d), 8'h34);

    // R3 hold handshake, then read transfers on channel 0
    ack_en = 1'b0; ack_pipe = 2'b00;
    push_run(0, 16'h1234, 3, K_RD);
    @(posedge clk); #1 drq = 4'b0001;
    repeat (6) @(negedge clk);
    chk_eq("R3 hold_req raised", int'(hold_req), 1);
    chk_eq("R3 no bus ownership before ack", int'(bus_own), 0);
    chk_eq("R3 no acknowledge before ack", int'(dack_n), 4'hf);
    ack_en = 1'b1;
    drain("R12 read run");
    @(posedge clk); #1 drq = 4'b0000;
    host_read(4'd8, d); chk_eq("R8 status tc bit 0", int'(d), 8'h01);
    host_read(4'd8, d); chk_eq("R8 status cleared by read", int'(d), 8'h00);
    host_write(4'd11, 8'h00);
    host_read(4'd0, d); chk_eq("R6 address low after run", int'(d), 8'h37);
    host_read(4'd0, d); chk_eq("R6 address high after run", int'(d), 8'h12);
    host_read(4'd1, d); chk_eq("R6 count low after run", int'(d), 8'h00);
    host_read(4'd1, d);

    // R13 zero count request ignored
    @(posedge clk); #1 drq = 4'b0001;
    repeat (8) @(negedge clk);
    chk_eq("R13 zero-count request ignored", int'(hold_req), 0);
    @(posedge clk); #1 drq = 4'b0000;

    // R5 write cycles with address carry (R6)
    program_ch(1, 16'h00FE, 14'd2, K_WR);
    push_run(1, 16'h00FE, 2, K_WR);
    @(posedge clk); #1 drq = 4'b0010;
    drain("R5 write run");
    @(posedge clk); #1 drq = 4'b0000;
    host_write(4'd11, 8'h00);
    host_read(4'd2, d); chk_eq("R6 carry low byte", int'(d), 8'h00);
    host_read(4'd2, d); chk_eq("R6 carry high byte", int'(d), 8'h01);

    // R10 fixed priority: channel 1 beats channel 2 at every choice
    program_ch(1, 16'h2000, 14'd2, K_RD);
    program_ch(2, 16'h3000, 14'd2, K_VER);
    push_item(1, 16'h2000, K_RD, 0, 0);
    push_item(1, 16'h2001, K_RD, 1, 0);
    push_item(2, 16'h3000, K_VER, 0, 0);
    push_item(2, 16'h3001, K_VER, 1, 0);
    @(posedge clk); #1 drq = 4'b0110;
    drain("R10 fixed order");
    @(posedge clk); #1 drq = 4'b0000;

    // R11 rotating priority: last serviced (channel 2) starts lowest
    host_write(4'd8, 8'h01);
    program_ch(1, 16'h4000, 14'd2, K_RD);
    program_ch(2, 16'h5000, 14'd2, K_RD);
    push_item(1, 16'h4000, K_RD, 0, 0);
    push_item(2, 16'h5000, K_RD, 0, 0);
    push_item(1, 16'h4001, K_RD, 1, 0);
    push_item(2, 16'h5001, K_RD, 1, 0);
    @(posedge clk); #1 drq = 4'b0110;
    drain("R11 rotating order");
    @(posedge clk); #1 drq = 4'b0000;

    // R7 wait states hold the strobe cycle
    program_ch(0, 16'h0040, 14'd1, K_RD);
    push_item(0, 16'h0040, K_RD, 1, 0);
    @(posedge clk); #1 ready = 0; drq = 4'b0001;
    begin
      int n;
      n = 0;
      while (memr_n && n < 200) begin @(negedge clk); n++; end
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk_eq("R7 strobes held in wait", int'({memr_n, memw_n, ior_n, iow_n}), 4'b0110);
      chk_eq("R7 address held in wait", int'(mem_addr), 16'h0040);
      chk_eq("R7 acknowledge held in wait", int'(dack_n), 4'b1110);
    end
    chk_eq("R7 no byte completed during wait", q.size(), 1);
    @(posedge clk); #1 ready = 1;
    drain("R7 wait run");
    @(posedge clk); #1 drq = 4'b0000;

    // R9 marker on byte 128 of a 130-byte verify run
    host_read(4'd8, d);
    program_ch(3, 16'h8000, 14'd130, K_VER);
    push_run(3, 16'h8000, 130, K_VER);
    @(posedge clk); #1 drq = 4'b1000;
    drain("R9 marker run");
    @(posedge clk); #1 drq = 4'b0000;
    host_read(4'd8, d); chk_eq("R8 status tc bit 3", int'(d), 8'h08);

    // R13 masked channel ignored
    host_write(4'd10, 8'h07);
    host_write(4'd11, 8'h00);
    host_write(4'd7, 8'h05);
    host_write(4'd7, 8'h00);
    @(posedge clk); #1 drq = 4'b1000;
    repeat (8) @(negedge clk);
    chk_eq("R13 masked request ignored", int'(hold_req), 0);
    @(posedge clk); #1 drq = 4'b0000;

    chk_eq("R4 no leftover expected bytes", q.size(), 0);
    summary_and_end();
  end
endmodule